// File: doc/BRIEF.md
# Banked Word Memory Controller

This block sits between a 16-bit processor and its external storage: a 32K-word RAM, a 32K-word ROM, a write-only screen buffer and one general-purpose I/O word. The processor presents byte addresses, but every access moves a full 16-bit word, so the lowest address bit plays no part in any decode. Reads see a 16K-word window whose bank is set by a small register. Writes always reach the full RAM, whatever bank is selected.

An external I/O controller can ask for the memory at any time. The processor is told to stall at once. Ownership moves to the I/O controller only at the boundary of an access, so an access that the processor has already presented is always carried out. The I/O controller then uses the same memory map. The RAM and ROM are synchronous: read data returns one clock after the select.

Top module: `memctl_top`

## Requirements
- R1: After reset both bank bits are 0, `gpioOut` is 0, `dmaGnt` is 0, `cpuStall` is 0, and a read of byte address 0x0000 selects ROM word 0.
- R2: Address bit 0 is ignored, so an odd byte address reaches the same word as the even address just below it.
- R3: A read with address bit 15 = 0 drives `romCs` with `romAddr` = {romBank, addr[14:1]}. A read with bit 15 = 1, outside the I/O words, drives `ramCs` with `ramAddr` = {ramBank, addr[14:1]}. The word appears on `memRdata` one clock after the read.
- R4: A write drives `ramCs` and `ramWe` with `ramAddr` = addr[15:1] and `ramWdata` equal to the write data, whatever the bank bits are. A write never selects the ROM.
- R5: A write to byte address 0xFFFC loads romBank from data bit 0 and ramBank from data bit 1. A read of 0xFFFC returns {14'b0, ramBank, romBank} and selects neither RAM nor ROM.
- R6: A write to byte address 0xFFFE loads `gpioOut` and is also written to RAM word 0x7FFF. A read of 0xFFFE/0xFFFF returns `gpioIn` as sampled in the read cycle and selects neither RAM nor ROM.
- R7: A write to a RAM word from 0x7F00 to 0x7F35 (54 words, byte 0xFE00 to 0xFE6B) also pulses `scrWe`, with `scrAddr` = word - 0x7F00 and `scrWdata` = write data. Writes outside that range, and all reads, leave `scrWe` low.
- R8: While `dmaGnt` is high, the device side follows `dmaAddr`/`dmaRd`/`dmaWr`/`dmaWdata` and processor strobes are ignored. `cpuStall` is high whenever `dmaReq` or `dmaGnt` is high.
- R9: `dmaGnt` rises on the clock after a cycle in which `dmaReq` is high and the processor presents no access. A processor access presented in the same cycle as the request is performed first. `dmaGnt` falls on the clock after `dmaReq` goes low.
- R10: `ramCs` and `romCs` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Processor byte address |
| cpuRd | input | 1 | Processor read strobe |
| cpuWr | input | 1 | Processor write strobe |
| cpuWdata | input | 16 | Processor write data |
| cpuStall | output | 1 | Processor must not start a new access |
| dmaReq | input | 1 | I/O controller requests the memory |
| dmaGnt | output | 1 | Memory is owned by the I/O controller |
| dmaAddr | input | 16 | I/O controller byte address |
| dmaRd | input | 1 | I/O controller read strobe |
| dmaWr | input | 1 | I/O controller write strobe |
| dmaWdata | input | 16 | I/O controller write data |
| memRdata | output | 16 | Read data, valid one clock after the read |
| ramCs | output | 1 | RAM select |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 15 | RAM word address |
| ramWdata | output | 16 | RAM write data |
| ramRdata | input | 16 | RAM read data |
| romCs | output | 1 | ROM select |
| romAddr | output | 15 | ROM word address |
| romRdata | input | 16 | ROM read data |
| scrWe | output | 1 | Screen buffer write strobe |
| scrAddr | output | 6 | Screen buffer word index |
| scrWdata | output | 16 | Screen buffer write data |
| gpioIn | input | 16 | General-purpose input word |
| gpioOut | output | 16 | General-purpose output word |

## Verification
The bench reads RAM with the RAM bank bit set and then written to the same byte address. A design that used the read window for writes, or dropped the bank bit, returns the wrong word. The screen-range edges (0xFDFE, 0xFE00, 0xFE6B, 0xFE6C) are probed, so an off-by-one range or a byte-based offset shows up as a missing or extra `scrWe`. Both I/O words are read and written, which catches a decoder that leaks them into RAM reads or fails to mirror the GPIO write. The request is raised in the same cycle as a processor write to prove that the write still lands and the grant waits one more clock. Processor strobes held during a grant must have no effect on the device side.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

  // Where the registered read data comes from in the cycle after a read
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2,
    SRC_IO   = 2'd3
  } rdSrc_e;

  // Decoded strobes passed from control to datapath
  typedef struct packed {
    logic romRd;
    logic ramRd;
    logic ramWr;
    logic bankRd;
    logic bankWr;
    logic gpioRd;
    logic gpioWr;
    logic scrHit;
  } memStrobe_t;

endpackage

// File: rtl/memctl_ctrl.sv
module memctl_ctrl
  import memctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned SCR_BASE_WORD = 'h7F00,
  parameter int unsigned SCR_WORDS     = 54,
  parameter int unsigned BANK_WORD     = 'h7FFE,
  parameter int unsigned GPIO_WORD     = 'h7FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic              dmaReq,
  input  logic              dmaRd,
  input  logic              dmaWr,
  input  logic [ADDR_W-2:0] busWord,
  output logic              dmaGnt,
  output logic              cpuStall,
  output memStrobe_t        strb
);
  localparam int unsigned WORD_W = ADDR_W - 1;
  localparam logic [WORD_W-1:0] SCR_LO = WORD_W'(SCR_BASE_WORD);
  localparam logic [WORD_W-1:0] SCR_HI = WORD_W'(SCR_BASE_WORD + SCR_WORDS);
  localparam logic [WORD_W-1:0] BANK_A = WORD_W'(BANK_WORD);
  localparam logic [WORD_W-1:0] GPIO_A = WORD_W'(GPIO_WORD);

  logic gntQ;
  logic cpuBusy;
  logic accRd, accWr;
  logic hitBank, hitGpio, hitScr, inRamWin;

  // Ownership changes only between accesses
  assign cpuBusy = cpuRd | cpuWr;

  always_ff @(posedge clk) begin
    if (!rstN) gntQ <= 1'b0;
    else       gntQ <= dmaReq & (gntQ | ~cpuBusy);
  end

  assign dmaGnt   = gntQ;
  assign cpuStall = dmaReq | gntQ;

  // Strobes of the current owner; a write wins over a read
  assign accWr = gntQ ? dmaWr : cpuWr;
  assign accRd = (gntQ ? dmaRd : cpuRd) & ~accWr;

  assign inRamWin = busWord[WORD_W-1];
  assign hitBank  = (busWord == BANK_A);
  assign hitGpio  = (busWord == GPIO_A);
  assign hitScr   = (busWord >= SCR_LO) && (busWord < SCR_HI);

  always_comb begin
    strb        = '0;
    strb.romRd  = accRd & ~inRamWin;
    strb.ramRd  = accRd & inRamWin & ~hitBank & ~hitGpio;
    strb.bankRd = accRd & hitBank;
    strb.gpioRd = accRd & hitGpio;
    strb.ramWr  = accWr;
    strb.bankWr = accWr & hitBank;
    strb.gpioWr = accWr & hitGpio;
    strb.scrHit = accWr & hitScr;
  end

endmodule

// File: rtl/memctl_dpath.sv
module memctl_dpath
  import memctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned SCR_BASE_WORD = 'h7F00,
  parameter int unsigned SCR_WORDS     = 54
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         dmaGnt,
  input  memStrobe_t                   strb,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [DATA_W-1:0]            cpuWdata,
  input  logic [ADDR_W-1:0]            dmaAddr,
  input  logic [DATA_W-1:0]            dmaWdata,
  output logic [ADDR_W-2:0]            busWord,
  output logic [DATA_W-1:0]            memRdata,
  output logic                         ramCs,
  output logic                         ramWe,
  output logic [ADDR_W-2:0]            ramAddr,
  output logic [DATA_W-1:0]            ramWdata,
  input  logic [DATA_W-1:0]            ramRdata,
  output logic                         romCs,
  output logic [ADDR_W-2:0]            romAddr,
  input  logic [DATA_W-1:0]            romRdata,
  output logic                         scrWe,
  output logic [$clog2(SCR_WORDS)-1:0] scrAddr,
  output logic [DATA_W-1:0]            scrWdata,
  input  logic [DATA_W-1:0]            gpioIn,
  output logic [DATA_W-1:0]            gpioOut
);
  localparam int unsigned WORD_W = ADDR_W - 1;
  localparam int unsigned WIN_W  = ADDR_W - 2;
  localparam int unsigned SCR_AW = $clog2(SCR_WORDS);

  logic [DATA_W-1:0] busData;
  logic              romBank, ramBank;
  logic [DATA_W-1:0] gpioQ;
  logic [DATA_W-1:0] ioData;
  rdSrc_e            rdSrc;
  logic              unusedLsb;

  // Word addressing: the byte-select bit carries no meaning
  assign unusedLsb = cpuAddr[0] ^ dmaAddr[0];

  assign busWord = dmaGnt ? dmaAddr[ADDR_W-1:1] : cpuAddr[ADDR_W-1:1];
  assign busData = dmaGnt ? dmaWdata : cpuWdata;

  // Device side
  assign ramCs    = strb.ramRd | strb.ramWr;
  assign ramWe    = strb.ramWr;
  assign ramAddr  = strb.ramWr ? busWord : {ramBank, busWord[WIN_W-1:0]};
  assign ramWdata = busData;
  assign romCs    = strb.romRd;
  assign romAddr  = {romBank, busWord[WIN_W-1:0]};

  // Screen mirror
  assign scrWe    = strb.scrHit;
  assign scrAddr  = SCR_AW'(busWord - WORD_W'(SCR_BASE_WORD));
  assign scrWdata = busData;

  // Bank and output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBank <= 1'b0;
      ramBank <= 1'b0;
      gpioQ   <= '0;
    end else begin
      if (strb.bankWr) begin
        romBank <= busData[0];
        ramBank <= busData[1];
      end
      if (strb.gpioWr) gpioQ <= busData;
    end
  end

  assign gpioOut = gpioQ;

  // Read return path, aligned with the synchronous memories
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSrc  <= SRC_NONE;
      ioData <= '0;
    end else begin
      if (strb.romRd)                      rdSrc <= SRC_ROM;
      else if (strb.ramRd)                 rdSrc <= SRC_RAM;
      else if (strb.bankRd | strb.gpioRd)  rdSrc <= SRC_IO;
      else                                 rdSrc <= SRC_NONE;
      if (strb.bankRd)      ioData <= {{(DATA_W-2){1'b0}}, ramBank, romBank};
      else if (strb.gpioRd) ioData <= gpioIn;
    end
  end

  always_comb begin
    unique case (rdSrc)
      SRC_ROM: memRdata = romRdata;
      SRC_RAM: memRdata = ramRdata;
      SRC_IO:  memRdata = ioData;
      default: memRdata = '0;
    endcase
  end

endmodule

// File: rtl/memctl_top.sv
module memctl_top
  import memctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned SCR_BASE_WORD = 'h7F00,
  parameter int unsigned SCR_WORDS     = 54,
  parameter int unsigned BANK_WORD     = 'h7FFE,
  parameter int unsigned GPIO_WORD     = 'h7FFF
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic                         cpuRd,
  input  logic                         cpuWr,
  input  logic [DATA_W-1:0]            cpuWdata,
  output logic                         cpuStall,
  input  logic                         dmaReq,
  output logic                         dmaGnt,
  input  logic [ADDR_W-1:0]            dmaAddr,
  input  logic                         dmaRd,
  input  logic                         dmaWr,
  input  logic [DATA_W-1:0]            dmaWdata,
  output logic [DATA_W-1:0]            memRdata,
  output logic                         ramCs,
  output logic                         ramWe,
  output logic [ADDR_W-2:0]            ramAddr,
  output logic [DATA_W-1:0]            ramWdata,
  input  logic [DATA_W-1:0]            ramRdata,
  output logic                         romCs,
  output logic [ADDR_W-2:0]            romAddr,
  input  logic [DATA_W-1:0]            romRdata,
  output logic                         scrWe,
  output logic [$clog2(SCR_WORDS)-1:0] scrAddr,
  output logic [DATA_W-1:0]            scrWdata,
  input  logic [DATA_W-1:0]            gpioIn,
  output logic [DATA_W-1:0]            gpioOut
);
  memStrobe_t        strb;
  logic [ADDR_W-2:0] busWord;

  memctl_ctrl #(
    .ADDR_W(ADDR_W), .SCR_BASE_WORD(SCR_BASE_WORD), .SCR_WORDS(SCR_WORDS),
    .BANK_WORD(BANK_WORD), .GPIO_WORD(GPIO_WORD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .dmaReq(dmaReq), .dmaRd(dmaRd), .dmaWr(dmaWr), .busWord(busWord),
    .dmaGnt(dmaGnt), .cpuStall(cpuStall), .strb(strb)
  );

  memctl_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SCR_BASE_WORD(SCR_BASE_WORD), .SCR_WORDS(SCR_WORDS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .dmaGnt(dmaGnt), .strb(strb),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .dmaAddr(dmaAddr), .dmaWdata(dmaWdata),
    .busWord(busWord), .memRdata(memRdata),
    .ramCs(ramCs), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .romCs(romCs), .romAddr(romAddr), .romRdata(romRdata),
    .scrWe(scrWe), .scrAddr(scrAddr), .scrWdata(scrWdata),
    .gpioIn(gpioIn), .gpioOut(gpioOut)
  );

endmodule

// File: rtl/memctl_checker.sv
module memctl_checker (
  input logic clk,
  input logic rstN,
  input logic cpuRd,
  input logic cpuWr,
  input logic dmaReq,
  input logic dmaGnt,
  input logic dmaRd,
  input logic dmaWr,
  input logic cpuStall,
  input logic ramCs,
  input logic ramWe,
  input logic romCs,
  input logic scrWe
);

  assert_one_device_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(ramCs && romCs));

  assert_write_to_ram_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramCs && !romCs));

  assert_screen_mirrors_ram_R7: assert property (@(posedge clk) disable iff (!rstN)
    scrWe |-> ramWe);

  assert_stall_on_request_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq || dmaGnt) |-> cpuStall);

  assert_cpu_ignored_in_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dmaGnt && !dmaRd && !dmaWr) |-> (!ramCs && !romCs && !scrWe));

  assert_grant_at_boundary_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaGnt) |-> ($past(dmaReq) && !$past(cpuRd || cpuWr)));

  assert_grant_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dmaReq |=> !dmaGnt);

endmodule

bind memctl_top memctl_checker u_chk (
  .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .dmaReq(dmaReq), .dmaGnt(dmaGnt), .dmaRd(dmaRd), .dmaWr(dmaWr),
  .cpuStall(cpuStall), .ramCs(ramCs), .ramWe(ramWe), .romCs(romCs), .scrWe(scrWe)
);

// File: tb/memctl_top_bench.sv
module memctl_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0, cpuWdata = '0, dmaAddr = '0, dmaWdata = '0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0, dmaReq = 1'b0, dmaRd = 1'b0, dmaWr = 1'b0;
  logic [15:0] gpioIn = '0;
  logic        cpuStall, dmaGnt, ramCs, ramWe, romCs, scrWe;
  logic [15:0] memRdata, ramWdata, scrWdata, gpioOut;
  logic [15:0] ramQ = '0, romQ = '0;
  logic [14:0] ramAddr, romAddr;
  logic [5:0]  scrAddr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  memctl_top u_memctl_top (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuWdata(cpuWdata), .cpuStall(cpuStall), .dmaReq(dmaReq), .dmaGnt(dmaGnt),
    .dmaAddr(dmaAddr), .dmaRd(dmaRd), .dmaWr(dmaWr), .dmaWdata(dmaWdata),
    .memRdata(memRdata), .ramCs(ramCs), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramQ), .romCs(romCs), .romAddr(romAddr),
    .romRdata(romQ), .scrWe(scrWe), .scrAddr(scrAddr), .scrWdata(scrWdata),
    .gpioIn(gpioIn), .gpioOut(gpioOut)
  );

  // Synchronous memory models
  function automatic logic [15:0] romFn(input logic [14:0] a);
    return {1'b0, a} ^ 16'hC3C3;
  endfunction

  logic [15:0] ramMem [int unsigned];

  always @(posedge clk) begin
    if (romCs) romQ <= romFn(romAddr);
    if (ramCs) begin
      if (ramWe) ramMem[int'(ramAddr)] = ramWdata;
      else       ramQ <= ramMem.exists(int'(ramAddr)) ? ramMem[int'(ramAddr)] : 16'h0000;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one processor access; outputs are checked after it returns
  task automatic cpuBegin(input logic wr, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRd = ~wr; cpuWr = wr; cpuWdata = d;
    #1;
  endtask

  task automatic cpuEnd();
    @(posedge clk); #1;
    cpuRd = 1'b0; cpuWr = 1'b0;
  endtask

  // {wr, addr, expRam, expRom, expAddr, expScr, expScrA}
  localparam int NV = 12;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 16'h0000, 1'b0, 1'b1, 15'h0000, 1'b0, 6'd0},   // R1 ROM word 0
    {1'b0, 16'h0001, 1'b0, 1'b1, 15'h0000, 1'b0, 6'd0},   // R2 odd address
    {1'b0, 16'h7FFE, 1'b0, 1'b1, 15'h3FFF, 1'b0, 6'd0},   // R3 top of ROM window
    {1'b0, 16'h8000, 1'b1, 1'b0, 15'h0000, 1'b0, 6'd0},   // R3 RAM window
    {1'b0, 16'hC005, 1'b1, 1'b0, 15'h2002, 1'b0, 6'd0},   // R3 R2 odd RAM read
    {1'b1, 16'h8000, 1'b1, 1'b0, 15'h4000, 1'b0, 6'd0},   // R4 full RAM write
    {1'b1, 16'h0010, 1'b1, 1'b0, 15'h0008, 1'b0, 6'd0},   // R4 low RAM write
    {1'b1, 16'hFE00, 1'b1, 1'b0, 15'h7F00, 1'b1, 6'd0},   // R7 first screen word
    {1'b1, 16'hFE6B, 1'b1, 1'b0, 15'h7F35, 1'b1, 6'd53},  // R7 last screen word
    {1'b1, 16'hFE6C, 1'b1, 1'b0, 15'h7F36, 1'b0, 6'd0},   // R7 above range
    {1'b1, 16'hFDFE, 1'b1, 1'b0, 15'h7EFF, 1'b0, 6'd0},   // R7 below range
    {1'b0, 16'hFE00, 1'b1, 1'b0, 15'h3F00, 1'b0, 6'd0}    // R7 read never mirrors
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    chk("R1 dmaGnt", dmaGnt, 0);
    chk("R1 cpuStall", cpuStall, 0);
    chk("R1 gpioOut", gpioOut, 0);

    // R5 R1 bank register reset value
    cpuBegin(1'b0, 16'hFFFC, 16'h0);
    chk("R5 bank read no ram", ramCs, 0);
    chk("R5 bank read no rom", romCs, 0);
    cpuEnd();
    chk("R1 bank reset", memRdata, 16'h0000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      cpuBegin(v[40], v[39:24], 16'h1000 + 16'(i));
      chk($sformatf("R3/R4 vec%0d ramCs", i), ramCs, v[23]);
      chk($sformatf("R3/R4 vec%0d romCs", i), romCs, v[22]);
      chk($sformatf("R3/R4 vec%0d addr", i), v[23] ? ramAddr : romAddr, v[21:7]);
      chk($sformatf("R7 vec%0d scrWe", i), scrWe, v[6]);
      if (v[6]) begin
        chk($sformatf("R7 vec%0d scrAddr", i), scrAddr, v[5:0]);
        chk($sformatf("R7 vec%0d scrWdata", i), scrWdata, 16'h1000 + 16'(i));
      end
      if (v[40]) chk($sformatf("R4 vec%0d ramWdata", i), ramWdata, 16'h1000 + 16'(i));
      cpuEnd();
    end

    // R3 ROM data returns one clock later
    cpuBegin(1'b0, 16'h0006, 16'h0);
    chk("R3 rom addr", romAddr, 15'h0003);
    cpuEnd();
    chk("R3 rom data", memRdata, romFn(15'h0003));

    // R3 RAM bank 0 does not see word 0x4000
    cpuBegin(1'b0, 16'h8000, 16'h0);
    cpuEnd();
    chk("R3 ram bank0 data", memRdata, 16'h0000);

    // R5 set ramBank=1, then the write of vector 5 becomes visible
    cpuBegin(1'b1, 16'hFFFC, 16'h0002);
    cpuEnd();
    cpuBegin(1'b0, 16'h8000, 16'h0);
    chk("R3 ram bank1 addr", ramAddr, 15'h4000);
    cpuEnd();
    chk("R3 ram bank1 data", memRdata, 16'h1005);
    cpuBegin(1'b0, 16'hFFFD, 16'h0);
    cpuEnd();
    chk("R5 bank readback", memRdata, 16'h0002);
    cpuBegin(1'b0, 16'h0000, 16'h0);
    chk("R5 rom bank still 0", romAddr, 15'h0000);
    cpuEnd();

    // R5 both banks set
    cpuBegin(1'b1, 16'hFFFC, 16'h0003);
    cpuEnd();
    cpuBegin(1'b0, 16'h0002, 16'h0);
    chk("R5 rom bank1 addr", romAddr, 15'h4001);
    cpuEnd();
    chk("R5 rom bank1 data", memRdata, romFn(15'h4001));
    cpuBegin(1'b1, 16'h0010, 16'hABCD);
    chk("R4 write ignores bank", ramAddr, 15'h0008);
    chk("R4 write no rom", romCs, 0);
    cpuEnd();

    // R6 GPIO word
    gpioIn = 16'hBEEF;
    cpuBegin(1'b0, 16'hFFFF, 16'h0);
    chk("R6 gpio read no ram", ramCs, 0);
    chk("R6 gpio read no rom", romCs, 0);
    cpuEnd();
    gpioIn = 16'h0000;
    chk("R6 gpio read data", memRdata, 16'hBEEF);
    cpuBegin(1'b1, 16'hFFFE, 16'h5A5A);
    chk("R6 gpio write ramWe", ramWe, 1);
    chk("R6 gpio write ramAddr", ramAddr, 15'h7FFF);
    cpuEnd();
    chk("R6 gpioOut", gpioOut, 16'h5A5A);

    // R8 R9 request while idle
    @(negedge clk);
    dmaReq = 1'b1;
    #1;
    chk("R8 stall on request", cpuStall, 1);
    chk("R9 no grant yet", dmaGnt, 0);
    @(posedge clk); #1;
    chk("R9 grant", dmaGnt, 1);
    @(negedge clk);
    cpuWr = 1'b1; cpuAddr = 16'h8000; cpuWdata = 16'h1111;
    dmaRd = 1'b1; dmaAddr = 16'h0004;
    #1;
    chk("R8 dma read rom", romCs, 1);
    chk("R8 dma read addr", romAddr, 15'h4002);
    chk("R8 cpu write ignored", ramWe, 0);
    @(posedge clk); #1;
    chk("R8 dma read data", memRdata, romFn(15'h4002));
    dmaRd = 1'b0;
    @(negedge clk);
    dmaWr = 1'b1; dmaAddr = 16'h8010; dmaWdata = 16'h7777;
    #1;
    chk("R8 dma write addr", ramAddr, 15'h4008);
    chk("R8 dma write data", ramWdata, 16'h7777);
    @(posedge clk); #1;
    dmaWr = 1'b0; cpuWr = 1'b0;
    @(negedge clk);
    chk("R8 idle grant no ram", ramCs, 0);
    dmaReq = 1'b0;
    @(posedge clk); #1;
    chk("R9 release", dmaGnt, 0);
    chk("R8 stall released", cpuStall, 0);

    // R9 request in the same cycle as a processor write
    @(negedge clk);
    dmaReq = 1'b1; cpuWr = 1'b1; cpuAddr = 16'h8020; cpuWdata = 16'h2222;
    #1;
    chk("R9 cpu write performed", ramWe, 1);
    chk("R9 cpu write addr", ramAddr, 15'h4010);
    chk("R9 cpu write data", ramWdata, 16'h2222);
    @(posedge clk); #1;
    cpuWr = 1'b0;
    chk("R9 grant waits", dmaGnt, 0);
    @(posedge clk); #1;
    chk("R9 grant after boundary", dmaGnt, 1);
    dmaReq = 1'b0;
    @(posedge clk); #1;
    chk("R9 final release", dmaGnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule